// File: doc/BRIEF.md
# Rectangle Host-Fill Address Generator

This block takes a rectangle draw command through a small register port and walks every pixel of that rectangle in raster order. The horizontal coordinate advances first; at the right edge it wraps back to the left edge and the vertical coordinate moves to the next row. Each step uses one 32-bit pixel word supplied by the host. For that word the block issues one framebuffer write, whose linear address is `y * STRIDE + x`.

Software first writes the command word, then the start corner, and last the end corner. The end-corner write is the one that arms the walk. After that, every host write to the execute alias shows up on a valid/ready stream and moves the walk on by one pixel. A busy bit in the status word stays set until the pixel at the end corner has been taken. While the framebuffer port is stalled, the host stream is held off.

Top module: `rect_fill_agen`

## Requirements
- R1: After reset, `status_o` is zero, `fb_valid_o` is low and `hd_ready_o` equals `!fb_stall_i`.
- R2: Both corner registers hold X in bits 31:16 and Y in bits 15:0. Register index 1 is the start corner and index 2 is the end corner. Each pixel write goes to address `y*STRIDE + x` (default STRIDE = 2048).
- R3: Register index 0 is the command word. A write to the end corner arms a walk only when the command word held at that time has opcode bits 1:0 = 2 (draw), address-mode bits 4:2 = 1 (block) and bit 6 = 1 (host colour). Any other command word leaves busy low.
- R4: Both corners are inclusive. The walk produces exactly (ex-sx+1)*(ey-sy+1) writes, with X moving fastest and rows in ascending Y.
- R5: Status bit 3 (busy) goes high on the cycle after an arming end-corner write. It goes low on the cycle after the pixel at (ex, ey) is accepted.
- R6: When ex < sx or ey < sy, the end-corner write completes at once. Busy stays low and no writes follow.
- R7: While busy is low, host words are accepted (`hd_ready_o` high when not stalled) and thrown away without any framebuffer write.
- R8: `hd_ready_o` is low whenever `fb_stall_i` is high. A pending write holds `fb_valid_o`, `fb_addr_o` and `fb_data_o` steady until a cycle without stall.
- R9: Register writes made while busy is high are ignored. The running walk keeps its corners, and an end-corner write does not re-arm.
- R10: `fb_data_o` carries the accepted host word unchanged, one cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register index: 0 command, 1 start, 2 end |
| reg_wdata_i | input | 32 | Register write data |
| status_o | output | 32 | Status word, bit 3 = busy |
| hd_valid_i | input | 1 | Host word present (execute-alias write) |
| hd_data_i | input | 32 | Host pixel word |
| hd_ready_o | output | 1 | Host word accepted this cycle |
| fb_valid_o | output | 1 | Framebuffer write pending |
| fb_addr_o | output | ADDR_W | Framebuffer linear address |
| fb_data_o | output | 32 | Framebuffer write data |
| fb_stall_i | input | 1 | Framebuffer port cannot take a write |

## Verification
The assertions watch every cycle for the following. A stalled write must hold steady. Data must pass through unchanged. The walk cursor must stay inside its latched corners. Busy must drop right after the final pixel. Busy may rise only after an end-corner write. A host word taken while idle must produce no write. Only the bench scenarios can show the rest: the full raster order and the write count, the inclusive corners, the rejection of inverted corners and of each wrong command-word field, and that register writes made during a walk leave its addresses unchanged.

// File: rtl/rfa_pkg.sv
package rfa_pkg;
  localparam int COORD_W  = 16;
  localparam int BUSY_BIT = 3;
  localparam int HOSTC_BIT = 6;

  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_READ = 2'd1,
    OP_DRAW = 2'd2,
    OP_S2S  = 2'd3
  } opcode_e;

  localparam logic [2:0] AM_BLOCK = 3'd1;

  localparam logic [1:0] REG_CMD   = 2'd0;
  localparam logic [1:0] REG_START = 2'd1;
  localparam logic [1:0] REG_END   = 2'd2;

  typedef struct packed {
    logic [COORD_W-1:0] x;
    logic [COORD_W-1:0] y;
  } coord_t;
endpackage

// File: rtl/rfa_cmd_regs.sv
module rfa_cmd_regs
  import rfa_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  input  logic        busy_i,
  output logic        arm_o,
  output coord_t      start_o,
  output coord_t      end_o
);
  logic   cmd_ok_q;
  coord_t start_q;
  logic   we_ok;
  coord_t wcoord;

  assign we_ok  = we_i && !busy_i;
  assign wcoord = coord_t'(wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_ok_q <= 1'b0;
      start_q  <= '0;
    end else if (we_ok) begin
      if (addr_i == REG_CMD)
        cmd_ok_q <= (wdata_i[1:0] == OP_DRAW) && (wdata_i[4:2] == AM_BLOCK)
                    && wdata_i[HOSTC_BIT];
      if (addr_i == REG_START)
        start_q <= wcoord;
    end
  end

  // inverted corners: command retires at once without arming
  assign arm_o = we_ok && (addr_i == REG_END) && cmd_ok_q &&
                 (wcoord.x >= start_q.x) && (wcoord.y >= start_q.y);
  assign start_o = start_q;
  assign end_o   = wcoord;

  a_r9_no_arm_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !arm_o);
endmodule

// File: rtl/rfa_walker.sv
module rfa_walker
  import rfa_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               arm_i,
  input  coord_t             start_i,
  input  coord_t             end_i,
  input  logic               step_i,
  output logic               busy_o,
  output logic [COORD_W-1:0] cur_x_o,
  output logic [COORD_W-1:0] cur_y_o
);
  logic               busy_q;
  logic [COORD_W-1:0] sx_q, ex_q, ey_q, cx_q, cy_q;
  logic               row_end, last;

  assign row_end = (cx_q == ex_q);
  assign last    = row_end && (cy_q == ey_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sx_q <= '0; ex_q <= '0; ey_q <= '0;
      cx_q <= '0; cy_q <= '0;
    end else if (arm_i && !busy_q) begin
      busy_q <= 1'b1;
      sx_q <= start_i.x;
      ex_q <= end_i.x;
      ey_q <= end_i.y;
      cx_q <= start_i.x;
      cy_q <= start_i.y;
    end else if (step_i && busy_q) begin
      if (row_end) begin
        cx_q <= sx_q;
        if (last) busy_q <= 1'b0;
        else      cy_q <= cy_q + 1'b1;
      end else begin
        cx_q <= cx_q + 1'b1;
      end
    end
  end

  assign busy_o  = busy_q;
  assign cur_x_o = cx_q;
  assign cur_y_o = cy_q;

  a_r5_clear_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && busy_q && last) |=> !busy_o);
  a_r4_x_in_rect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cx_q >= sx_q) && (cx_q <= ex_q));
  a_r4_y_in_rect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cy_q <= ey_q));
endmodule

// File: rtl/rfa_fb_stage.sv
module rfa_fb_stage
  import rfa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STRIDE = 2048
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fire_i,
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  input  logic [31:0]        data_i,
  input  logic               stall_i,
  output logic               valid_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [31:0]        data_o
);
  localparam logic [ADDR_W-1:0] STRIDE_V = ADDR_W'(STRIDE);

  logic [ADDR_W-1:0] lin_addr;
  assign lin_addr = ADDR_W'(y_i) * STRIDE_V + ADDR_W'(x_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      data_o  <= '0;
    end else if (!stall_i) begin
      valid_o <= fire_i;
      if (fire_i) begin
        addr_o <= lin_addr;
        data_o <= data_i;
      end
    end
  end

  a_r8_hold_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && stall_i) |=> valid_o && $stable(addr_o) && $stable(data_o));
  a_r10_data_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> valid_o && (data_o == $past(data_i)));
endmodule

// File: rtl/rect_fill_agen.sv
module rect_fill_agen
  import rfa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STRIDE = 2048
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       status_o,
  input  logic              hd_valid_i,
  input  logic [31:0]       hd_data_i,
  output logic              hd_ready_o,
  output logic              fb_valid_o,
  output logic [ADDR_W-1:0] fb_addr_o,
  output logic [31:0]       fb_data_o,
  input  logic              fb_stall_i
);
  logic               arm, busy, step;
  coord_t             start_c, end_c;
  logic [COORD_W-1:0] cur_x, cur_y;

  assign hd_ready_o = !fb_stall_i;
  // idle host words are accepted and dropped
  assign step = hd_valid_i && hd_ready_o && busy;

  rfa_cmd_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .busy_i(busy), .arm_o(arm), .start_o(start_c), .end_o(end_c)
  );

  rfa_walker u_walk (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .arm_i(arm), .start_i(start_c), .end_i(end_c), .step_i(step),
    .busy_o(busy), .cur_x_o(cur_x), .cur_y_o(cur_y)
  );

  rfa_fb_stage #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_fb (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .fire_i(step), .x_i(cur_x), .y_i(cur_y), .data_i(hd_data_i),
    .stall_i(fb_stall_i),
    .valid_o(fb_valid_o), .addr_o(fb_addr_o), .data_o(fb_data_o)
  );

  always_comb begin
    status_o = '0;
    status_o[BUSY_BIT] = busy;
  end

  a_r3_rise_after_end_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(reg_we_i && (reg_addr_i == REG_END)));
  a_r7_idle_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && hd_valid_i && hd_ready_o) |=> !fb_valid_o);
endmodule

// File: tb/rect_fill_agen_tb.sv
module rect_fill_agen_tb;
  localparam int STRIDE = 2048;
  localparam logic [31:0] CMD_OK = 32'h46;

  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] status;
  logic        hd_valid = 0;
  logic [31:0] hd_data = 0;
  logic        hd_ready;
  logic        fb_valid;
  logic [31:0] fb_addr, fb_data;
  logic        fb_stall = 0;

  int total = 0, bad = 0;
  logic [31:0] exp_addr[$];
  logic [31:0] exp_data[$];
  logic        prev_stalled = 0;
  logic [31:0] prev_addr, prev_data;

  always #4 clk = ~clk;

  rect_fill_agen #(.ADDR_W(32), .STRIDE(STRIDE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .status_o(status),
    .hd_valid_i(hd_valid), .hd_data_i(hd_data), .hd_ready_o(hd_ready),
    .fb_valid_o(fb_valid), .fb_addr_o(fb_addr), .fb_data_o(fb_data),
    .fb_stall_i(fb_stall)
  );

  function automatic logic [31:0] lin(input int x, input int y);
    return 32'(y * STRIDE + x);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: 1 ns before each rising edge
  initial forever begin
    @(negedge clk); #3;
    if (prev_stalled) begin
      chk(fb_valid && fb_addr == prev_addr && fb_data == prev_data, "R8 hold",
          fb_addr, prev_addr);
      prev_stalled = 0;
    end
    if (fb_valid && fb_stall) begin
      prev_stalled = 1; prev_addr = fb_addr; prev_data = fb_data;
    end else if (fb_valid) begin
      if (exp_addr.size() == 0) begin
        chk(0, "R7/R6 unexpected write", fb_addr, 32'hx);
      end else begin
        logic [31:0] ea, ed;
        ea = exp_addr.pop_front(); ed = exp_data.pop_front();
        chk(fb_addr == ea, "R2/R4 addr", fb_addr, ea);
        chk(fb_data == ed, "R10 data", fb_data, ed);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic check_busy(input bit exp, input string req);
    #3;
    chk(status == (exp ? 32'h8 : 32'h0), req, status, exp ? 32'h8 : 32'h0);
    @(negedge clk);
  endtask

  task automatic send(input logic [31:0] d, input int stall_pct);
    bit ok;
    hd_valid = 1; hd_data = d;
    do begin
      fb_stall = ($urandom_range(99) < stall_pct);
      #3;
      ok = hd_ready;
      if (fb_stall) chk(!hd_ready, "R8 ready low", 32'(hd_ready), 0);
      @(negedge clk);
    end while (!ok);
    hd_valid = 0; fb_stall = 0;
  endtask

  task automatic drain(input string req);
    fb_stall = 0;
    repeat (3) @(negedge clk);
    chk(status == 0, {req, " busy cleared"}, status, 0);
    chk(exp_addr.size() == 0, {req, " write count"}, 32'(exp_addr.size()), 0);
  endtask

  task automatic run_rect(input int x0, input int y0, input int x1, input int y1,
                          input int stall_pct);
    wr(2'd0, CMD_OK);
    wr(2'd1, {16'(x0), 16'(y0)});
    wr(2'd2, {16'(x1), 16'(y1)});
    check_busy(1, "R5 busy set");
    for (int y = y0; y <= y1; y++)
      for (int x = x0; x <= x1; x++) begin
        logic [31:0] d;
        d = $urandom;
        exp_addr.push_back(lin(x, y)); exp_data.push_back(d);
        send(d, stall_pct);
      end
    drain("R4/R5");
  endtask

  initial begin
    #(8 * 150000);
    chk(0, "watchdog", 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (2) @(negedge clk);
    #3;
    chk(status == 0, "R1 status", status, 0);
    chk(!fb_valid, "R1 fb_valid", 32'(fb_valid), 0);
    chk(hd_ready, "R1 ready", 32'(hd_ready), 1);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R4 R2: 3x2 directed, inclusive corners
    run_rect(5, 7, 7, 8, 0);
    // single pixel
    run_rect(2047, 3, 2047, 3, 0);

    // R3: wrong opcode, wrong address mode, missing host-colour bit
    wr(2'd0, 32'h45); wr(2'd1, {16'd1, 16'd1}); wr(2'd2, {16'd2, 16'd2});
    check_busy(0, "R3 opcode read");
    wr(2'd0, 32'h4A); wr(2'd2, {16'd2, 16'd2});
    check_busy(0, "R3 addr mode");
    wr(2'd0, 32'h06); wr(2'd2, {16'd2, 16'd2});
    check_busy(0, "R3 host bit");
    // R7: idle host data dropped
    send(32'hdead_beef, 0);
    send(32'h1234_5678, 0);
    drain("R7 idle");

    // R6: inverted corners
    wr(2'd0, CMD_OK); wr(2'd1, {16'd10, 16'd5}); wr(2'd2, {16'd9, 16'd6});
    check_busy(0, "R6 x inverted");
    wr(2'd2, {16'd11, 16'd4});
    check_busy(0, "R6 y inverted");
    send(32'hcafe_0001, 0);
    drain("R6");

    // R9: register writes during a walk are ignored
    wr(2'd0, CMD_OK); wr(2'd1, {16'd10, 16'd20}); wr(2'd2, {16'd11, 16'd21});
    check_busy(1, "R9 armed");
    exp_addr.push_back(lin(10, 20)); exp_data.push_back(32'h1);
    send(32'h1, 0);
    wr(2'd1, {16'd100, 16'd100});
    wr(2'd2, {16'd200, 16'd200});
    wr(2'd0, 32'h0);
    exp_addr.push_back(lin(11, 20)); exp_data.push_back(32'h2); send(32'h2, 0);
    exp_addr.push_back(lin(10, 21)); exp_data.push_back(32'h3); send(32'h3, 0);
    exp_addr.push_back(lin(11, 21)); exp_data.push_back(32'h4); send(32'h4, 0);
    drain("R9");
    send(32'h5, 0);
    drain("R9 no re-arm");

    // R8 and random sweep
    for (int i = 0; i < 24; i++) begin
      int x0, y0;
      x0 = $urandom_range(2000);
      y0 = $urandom_range(1000);
      run_rect(x0, y0, x0 + $urandom_range(7), y0 + $urandom_range(3), 35);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule